// File: doc/BRIEF.md
# Keyboard/Mouse Output Buffer Arbiter

This block sits between the two reply channels of a keyboard controller (one for the keyboard, one for the pointing device) and the host-facing side. Each channel raises a level while it holds a byte the host has not read yet. The block registers both levels into a two-bit pending mask and derives the host-visible flags from it: the "output buffer full" status bit and its copy in the output port, the "mouse buffer full" status bit and its copy, the two interrupt request levels, and the select that tells the data-read path which channel's queue a host read pops.

The keyboard channel has strict priority. The mouse flags, the mouse interrupt and the mouse read-select appear only when the mouse alone is pending. The block also holds the controller's configuration (mode) byte. The host can rewrite that byte in full. The controller's keyboard enable and disable commands act on the disable bit only. The mode byte is also driven out so that the controller can return it on a read-mode command. All flag outputs are combinational from the registered mask and mode, so they follow either register in the cycle after it changes.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset the pending mask is empty and the mode byte is 0x03. `mode_o` reads 0x03 and every flag and interrupt output is low.
- R2: At each clock edge the pending mask takes bit 0 from `kbd_avail` and bit 1 from `aux_avail`. The flag outputs reflect the new mask from that edge onward.
- R3: `stat_obf` and `oport_obf` are high exactly when at least one channel is pending.
- R4: `stat_aux_obf` and `oport_aux_obf` are high exactly when the mask is "mouse only" (bit 1 set, bit 0 clear).
- R5: `aux_irq` is high exactly when the mask is "mouse only" and mode bit 1 is set.
- R6: `kbd_irq` is high exactly when keyboard data is pending (mask bit 0 set, whatever bit 1 holds), mode bit 0 is set, and mode bit 4 (keyboard disable) is clear.
- R7: `rd_sel_aux` is high, selecting the mouse queue for the next host read, exactly when the mask is "mouse only". Otherwise it is low and the keyboard queue is selected.
- R8: A cycle with `mode_we` high and no keyboard command loads `mode_wdata` into the mode byte at that edge, as seen on `mode_o`.
- R9: `kbd_off_cmd` alone sets mode bit 4. `kbd_on_cmd` alone clears it. Both together leave bit 4 unchanged. Neither command changes any other mode bit.
- R10: When a keyboard command coincides with `mode_we`, the command's effect on bit 4 is applied on top of the written byte.
- R11: Both interrupt outputs are low whenever the pending mask is empty, for any mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_avail | input | 1 | Keyboard channel holds unread data |
| aux_avail | input | 1 | Mouse channel holds unread data |
| mode_we | input | 1 | Write the full mode byte |
| mode_wdata | input | 8 | New mode byte |
| kbd_off_cmd | input | 1 | Keyboard-disable command executes |
| kbd_on_cmd | input | 1 | Keyboard-enable command executes |
| mode_o | output | 8 | Current mode byte |
| stat_obf | output | 1 | Status: output buffer full |
| stat_aux_obf | output | 1 | Status: buffer holds mouse data |
| oport_obf | output | 1 | Output-port copy of buffer full |
| oport_aux_obf | output | 1 | Output-port copy of mouse buffer full |
| kbd_irq | output | 1 | Keyboard interrupt request level |
| aux_irq | output | 1 | Mouse interrupt request level |
| rd_sel_aux | output | 1 | Host data read pops the mouse queue |

## Verification
The bench builds the block with its default 8-bit mode byte and the default bit positions for the two interrupt enables and the keyboard disable. At that size every mode value can be paired with every one of the four pending masks, 1024 cases in all. This covers every gating combination of the interrupts and the priority rule. Directed sequences then drive the enable and disable commands alone, together, and coinciding with a mode write, and read the result both on `mode_o` and on the keyboard interrupt.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

    // Pending mask bit positions: the priority rule decodes them.
    localparam int unsigned PEND_KBD = 0;
    localparam int unsigned PEND_AUX = 1;
    localparam int unsigned PEND_W   = 2;

    typedef logic [PEND_W-1:0] pend_t;

    localparam pend_t PEND_AUX_ONLY = pend_t'(1 << PEND_AUX);

    typedef struct packed {
        logic obf;
        logic aux_obf;
        logic kbd_irq;
        logic aux_irq;
        logic sel_aux;
    } flags_t;

endpackage

// File: rtl/obuf_pending.sv
module obuf_pending
    import obuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  kbd_avail,
    input  logic  aux_avail,
    output pend_t pend_o
);

    typedef struct packed {
        pend_t pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend[PEND_KBD] = kbd_avail;
        st_d.pend[PEND_AUX] = aux_avail;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.pend == {$past(aux_avail), $past(kbd_avail)})); // R2

endmodule

// File: rtl/obuf_mode.sv
module obuf_mode #(
    parameter int unsigned          MODE_W  = 8,
    parameter int unsigned          OFF_BIT = 4,
    parameter logic [MODE_W-1:0]    RST_VAL = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    input  logic              off_cmd,
    input  logic              on_cmd,
    output logic [MODE_W-1:0] mode_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } mode_state_t;

    mode_state_t st_d, st_q;
    logic [MODE_W-1:0] base;

    always_comb begin
        st_d = st_q;
        base = we ? wdata : st_q.mode;
        st_d.mode = base;
        if (off_cmd && !on_cmd)      st_d.mode[OFF_BIT] = 1'b1;
        else if (on_cmd && !off_cmd) st_d.mode[OFF_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.mode <= RST_VAL;
        else        st_q      <= st_d;
    end

    assign mode_o = st_q.mode;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !off_cmd && !on_cmd) |=> (mode_o == $past(wdata))); // R8

    AST_OFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (off_cmd && !on_cmd) |=> mode_o[OFF_BIT]); // R9

    AST_ON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (on_cmd && !off_cmd) |=> !mode_o[OFF_BIT]); // R9

endmodule

// File: rtl/obuf_decode.sv
module obuf_decode
    import obuf_pkg::*;
(
    input  pend_t  pend,
    input  logic   kbd_irq_en,
    input  logic   aux_irq_en,
    input  logic   kbd_off,
    output flags_t flags
);

    logic any_pend;
    logic aux_only;

    always_comb begin
        any_pend = |pend;
        aux_only = (pend == PEND_AUX_ONLY);
        flags.obf     = any_pend;
        flags.aux_obf = aux_only;
        flags.sel_aux = aux_only;
        flags.aux_irq = aux_only && aux_irq_en;
        flags.kbd_irq = pend[PEND_KBD] && kbd_irq_en && !kbd_off;
    end

    always_comb begin
        AST_ONE_IRQ: assert (!(flags.kbd_irq && flags.aux_irq)); // R5
    end

endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
    import obuf_pkg::*;
#(
    parameter int unsigned          MODE_W      = 8,
    parameter int unsigned          KBD_IRQ_BIT = 0,
    parameter int unsigned          AUX_IRQ_BIT = 1,
    parameter int unsigned          KBD_OFF_BIT = 4,
    parameter logic [MODE_W-1:0]    MODE_RST    = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_avail,
    input  logic              aux_avail,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              kbd_off_cmd,
    input  logic              kbd_on_cmd,
    output logic [MODE_W-1:0] mode_o,
    output logic              stat_obf,
    output logic              stat_aux_obf,
    output logic              oport_obf,
    output logic              oport_aux_obf,
    output logic              kbd_irq,
    output logic              aux_irq,
    output logic              rd_sel_aux
);

    pend_t             pend_q;
    logic [MODE_W-1:0] mode_q;
    flags_t            flags;

    obuf_pending u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_avail (kbd_avail),
        .aux_avail (aux_avail),
        .pend_o    (pend_q)
    );

    obuf_mode #(
        .MODE_W  (MODE_W),
        .OFF_BIT (KBD_OFF_BIT),
        .RST_VAL (MODE_RST)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mode_we),
        .wdata   (mode_wdata),
        .off_cmd (kbd_off_cmd),
        .on_cmd  (kbd_on_cmd),
        .mode_o  (mode_q)
    );

    obuf_decode u_dec (
        .pend       (pend_q),
        .kbd_irq_en (mode_q[KBD_IRQ_BIT]),
        .aux_irq_en (mode_q[AUX_IRQ_BIT]),
        .kbd_off    (mode_q[KBD_OFF_BIT]),
        .flags      (flags)
    );

    assign mode_o        = mode_q;
    assign stat_obf      = flags.obf;
    assign oport_obf     = flags.obf;
    assign stat_aux_obf  = flags.aux_obf;
    assign oport_aux_obf = flags.aux_obf;
    assign kbd_irq       = flags.kbd_irq;
    assign aux_irq       = flags.aux_irq;
    assign rd_sel_aux    = flags.sel_aux;

    AST_AUX_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_aux_obf |-> stat_obf); // R4

    AST_KBD_IRQ_NOT_AUX: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_irq |-> (!rd_sel_aux && stat_obf)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_obf |-> (!kbd_irq && !aux_irq)); // R11

    AST_SEL_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_aux |-> (stat_aux_obf && !kbd_irq)); // R7

endmodule

// File: tb/tb_obuf_arbiter.sv
`timescale 1ns/1ps
module tb_obuf_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_avail = 1'b0, aux_avail = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       kbd_off_cmd = 1'b0, kbd_on_cmd = 1'b0;
    logic [7:0] mode_o;
    logic       stat_obf, stat_aux_obf, oport_obf, oport_aux_obf;
    logic       kbd_irq, aux_irq, rd_sel_aux;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    obuf_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .kbd_avail(kbd_avail), .aux_avail(aux_avail),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .kbd_off_cmd(kbd_off_cmd), .kbd_on_cmd(kbd_on_cmd),
        .mode_o(mode_o),
        .stat_obf(stat_obf), .stat_aux_obf(stat_aux_obf),
        .oport_obf(oport_obf), .oport_aux_obf(oport_aux_obf),
        .kbd_irq(kbd_irq), .aux_irq(aux_irq), .rd_sel_aux(rd_sel_aux)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; outputs are read at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(input logic [1:0] p, input logic [7:0] m);
        logic any, aonly, ki, ai;
        any   = p[0] | p[1];
        aonly = (p == 2'b10);
        ki    = p[0] & m[0] & ~m[4];
        ai    = aonly & m[1];
        chk("R3 stat_obf",      {7'b0, stat_obf},      {7'b0, any});
        chk("R3 oport_obf",     {7'b0, oport_obf},     {7'b0, any});
        chk("R4 stat_aux_obf",  {7'b0, stat_aux_obf},  {7'b0, aonly});
        chk("R4 oport_aux_obf", {7'b0, oport_aux_obf}, {7'b0, aonly});
        chk("R5 aux_irq",       {7'b0, aux_irq},       {7'b0, ai});
        chk("R6 kbd_irq",       {7'b0, kbd_irq},       {7'b0, ki});
        chk("R7 rd_sel_aux",    {7'b0, rd_sel_aux},    {7'b0, aonly});
        if (p == 2'b00)
            chk("R11 irqs idle", {6'b0, kbd_irq, aux_irq}, 8'h00);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        // R1: reset state
        chk("R1 mode reset", mode_o, 8'h03);
        chk("R1 flags reset", {1'b0, stat_obf, stat_aux_obf, oport_obf, oport_aux_obf,
                               kbd_irq, aux_irq, rd_sel_aux}, 8'h00);
        rst_n = 1'b1;
        step();

        // R2/R8 sweep: every mode byte against every pending mask
        for (int m = 0; m < 256; m++) begin
            for (int p = 0; p < 4; p++) begin
                mode_we    = 1'b1;
                mode_wdata = 8'(m);
                kbd_avail  = p[0];
                aux_avail  = p[1];
                step();
                mode_we = 1'b0;
                chk("R8 mode load", mode_o, 8'(m));
                chk("R2 mask capture", {7'b0, stat_obf}, {7'b0, (p != 0)});
                check_flags(2'(p), 8'(m));
            end
        end

        // R9: disable command alone, keyboard pending
        mode_we = 1'b1; mode_wdata = 8'h03; kbd_avail = 1'b1; aux_avail = 1'b0;
        step();
        mode_we = 1'b0;
        chk("R6 kbd irq enabled", {7'b0, kbd_irq}, 8'h01);
        kbd_off_cmd = 1'b1;
        step();
        kbd_off_cmd = 1'b0;
        chk("R9 off sets bit4", mode_o, 8'h13);
        chk("R9 off masks kbd irq", {7'b0, kbd_irq}, 8'h00);
        // R9: both commands leave bit 4 unchanged
        kbd_off_cmd = 1'b1; kbd_on_cmd = 1'b1;
        step();
        kbd_off_cmd = 1'b0; kbd_on_cmd = 1'b0;
        chk("R9 both keep bit4 set", mode_o, 8'h13);
        kbd_on_cmd = 1'b1;
        step();
        kbd_on_cmd = 1'b0;
        chk("R9 on clears bit4", mode_o, 8'h03);
        chk("R9 on restores kbd irq", {7'b0, kbd_irq}, 8'h01);
        kbd_off_cmd = 1'b1; kbd_on_cmd = 1'b1;
        step();
        kbd_off_cmd = 1'b0; kbd_on_cmd = 1'b0;
        chk("R9 both keep bit4 clear", mode_o, 8'h03);

        // R9: mouse-only pending, disable leaves mouse irq enable bit alone
        kbd_avail = 1'b0; aux_avail = 1'b1; kbd_off_cmd = 1'b1;
        step();
        kbd_off_cmd = 1'b0;
        chk("R9 off keeps bit1", mode_o, 8'h13);
        chk("R5 aux irq after off", {7'b0, aux_irq}, 8'h01);

        // R10: command overlays a coincident write
        kbd_avail = 1'b1; aux_avail = 1'b1;
        mode_we = 1'b1; mode_wdata = 8'h01; kbd_off_cmd = 1'b1;
        step();
        mode_we = 1'b0; kbd_off_cmd = 1'b0;
        chk("R10 write+off", mode_o, 8'h11);
        chk("R10 kbd irq masked", {7'b0, kbd_irq}, 8'h00);
        mode_we = 1'b1; mode_wdata = 8'hF3; kbd_on_cmd = 1'b1;
        step();
        mode_we = 1'b0; kbd_on_cmd = 1'b0;
        chk("R10 write+on", mode_o, 8'hE3);
        chk("R6 both pending kbd wins", {6'b0, kbd_irq, rd_sel_aux}, 8'h02);

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        step();
        chk("R1 mode after reset", mode_o, 8'h03);
        chk("R1 flags after reset", {7'b0, stat_obf}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule